// File: doc/BRIEF.md
# Coin Accumulator with Threshold Flag

This block keeps a running credit for a vending machine. Each coin insertion is marked by a strobe. Three denomination lines name the coin: five, ten or twenty-five cents. On a valid insertion the block adds the coin's value to the stored credit and writes the result back. A registered flag tells the machine when the credit has reached thirty cents.

The strobe arrives from coin-sensing logic that may not share the block's clock. It passes through a synchronizer and an edge detector, so one insertion adds exactly once however long the strobe stays high. The denomination lines travel through the same synchronizer stages, so the selected value stays aligned with the detected edge. A strobe is ignored when none of the denomination lines is high or when more than one is high. The credit register never wraps: it saturates at its largest code.

The credit logic is a three-state machine:
- `ST_SHORT`: credit is below the threshold.
- `ST_PAID`: credit is at or above the threshold but not saturated.
- `ST_FULL`: credit is held at the saturation value.

Each accepted coin takes one of these transitions:
- `ST_SHORT` stays in `ST_SHORT` (stay_short) while the new sum is under the threshold.
- `ST_SHORT` goes to `ST_PAID` (short_to_paid) when the new sum reaches the threshold.
- `ST_SHORT` goes to `ST_FULL` (short_to_full) when the new sum reaches saturation.
- `ST_PAID` stays in `ST_PAID` (stay_paid) below saturation.
- `ST_PAID` goes to `ST_FULL` (paid_to_full) at saturation.
- `ST_FULL` stays in `ST_FULL` (stay_full) on any coin.

Reset (reset_to_short) returns the machine to `ST_SHORT` from any state.

Top module: `coin_accumulator`

## Requirements
- R1: While `rst_n` is low, `credit_total` is 0 and `credit_met` is 0. Both outputs stay at those values at the first clock edge after release.
- R2: A strobe with only `sel_nickel` high adds 5 to `credit_total`.
- R3: A strobe with only `sel_dime` high adds 10 to `credit_total`.
- R4: A strobe with only `sel_quarter` high adds 25 to `credit_total`.
- R5: `credit_total` changes only on a rising edge of `coin_pulse`. Toggling the denomination lines while `coin_pulse` stays low leaves it unchanged.
- R6: Holding `coin_pulse` high for many cycles adds the selected coin only once. A changed total stays unchanged for at least the following cycle.
- R7: A strobe with zero denomination lines high, or with two or more high, leaves `credit_total` and `credit_met` unchanged.
- R8: `credit_met` is 1 exactly when `credit_total` is 30 or more. It changes on the same clock edge as `credit_total`. At 25 it is 0, and at 30 it is 1.
- R9: A sum above 63 is stored as 63. Once at 63, the total stays at 63 and `credit_met` stays 1. Without reset, the total never decreases.
- R10: With `coin_pulse` set high between clock edges, the new total is visible after the third rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the credit |
| coin_pulse | input | 1 | Insertion strobe, asynchronous to clk |
| sel_nickel | input | 1 | Coin is a 5-cent piece |
| sel_dime | input | 1 | Coin is a 10-cent piece |
| sel_quarter | input | 1 | Coin is a 25-cent piece |
| credit_total | output | 6 | Stored credit in cents, saturating at 63 |
| credit_met | output | 1 | Registered flag, high when credit is 30 or more |

## Verification
A wrong state register shows up directly: `credit_met` disagrees with `credit_total` on the very next edge after an accepted coin. A broken edge detector shows up as a second increment one cycle after the first when the strobe is held. A wrong decode or adder shows up as an increment that is not 5, 10 or 25, visible three edges after the strobe. A wrapping adder shows up as a total that falls below its previous value, with the flag dropping on the same edge.

// File: rtl/coin_acc_pkg.sv
package coin_acc_pkg;

    // Credit region tracked by the state machine
    typedef enum logic [1:0] {
        ST_SHORT = 2'd0,
        ST_PAID  = 2'd1,
        ST_FULL  = 2'd2
    } credit_state_t;

    // Denomination selected by a synchronized strobe
    typedef enum logic [1:0] {
        COIN_NONE    = 2'd0,
        COIN_NICKEL  = 2'd1,
        COIN_DIME    = 2'd2,
        COIN_QUARTER = 2'd3
    } coin_kind_t;

    // Bit positions of the denomination bundle
    localparam int SEL_NICKEL_BIT  = 0;
    localparam int SEL_DIME_BIT    = 1;
    localparam int SEL_QUARTER_BIT = 2;
    localparam int SEL_W           = 3;

endpackage

// File: rtl/coin_strobe_sync.sv
module coin_strobe_sync #(
    parameter int STAGES = 2,
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              strobe_rise,
    output logic [DATA_W-1:0] data_out
);

    logic [STAGES-1:0] strb_q;
    logic [DATA_W-1:0] data_q [STAGES];
    logic              strb_last_q;

    // Synchronizer chain: the strobe and the denomination lines move together
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        strb_q[g] <= 1'b0;
                        data_q[g] <= '0;
                    end else begin
                        strb_q[g] <= strobe_in;
                        data_q[g] <= data_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        strb_q[g] <= 1'b0;
                        data_q[g] <= '0;
                    end else begin
                        strb_q[g] <= strb_q[g-1];
                        data_q[g] <= data_q[g-1];
                    end
                end
            end
        end
    endgenerate

    // Keep the previous synchronized strobe to find its rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_last_q <= 1'b0;
        end else begin
            strb_last_q <= strb_q[STAGES-1];
        end
    end

    assign strobe_rise = strb_q[STAGES-1] & ~strb_last_q;
    assign data_out    = data_q[STAGES-1];

endmodule

// File: rtl/coin_value_decode.sv
module coin_value_decode
    import coin_acc_pkg::*;
#(
    parameter int VAL_W       = 6,
    parameter int NICKEL_VAL  = 5,
    parameter int DIME_VAL    = 10,
    parameter int QUARTER_VAL = 25
) (
    input  logic [SEL_W-1:0] sel,
    output logic             coin_ok,
    output logic [VAL_W-1:0] coin_val
);

    coin_kind_t kind;

    // Exactly one line must be high; otherwise no coin is recognized
    always_comb begin
        kind = COIN_NONE;
        if ($onehot(sel)) begin
            if (sel[SEL_NICKEL_BIT]) begin
                kind = COIN_NICKEL;
            end else if (sel[SEL_DIME_BIT]) begin
                kind = COIN_DIME;
            end else begin
                kind = COIN_QUARTER;
            end
        end
    end

    always_comb begin
        coin_ok  = 1'b1;
        coin_val = '0;
        unique case (kind)
            COIN_NICKEL:  coin_val = VAL_W'(NICKEL_VAL);
            COIN_DIME:    coin_val = VAL_W'(DIME_VAL);
            COIN_QUARTER: coin_val = VAL_W'(QUARTER_VAL);
            COIN_NONE:    coin_ok  = 1'b0;
        endcase
    end

endmodule

// File: rtl/credit_fsm.sv
module credit_fsm
    import coin_acc_pkg::*;
#(
    parameter int TOTAL_W   = 6,
    parameter int THRESHOLD = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [TOTAL_W-1:0] add_val,
    output logic [TOTAL_W-1:0] total,
    output logic               met
);

    localparam int              SUM_W   = TOTAL_W + 1;
    localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << TOTAL_W) - 1);
    localparam logic [SUM_W-1:0] THR     = SUM_W'(THRESHOLD);

    credit_state_t      state_q, state_d;
    logic [TOTAL_W-1:0] total_q, total_d;
    logic [SUM_W-1:0]   raw_sum;
    logic [SUM_W-1:0]   clipped;

    assign raw_sum = {1'b0, total_q} + {1'b0, add_val};
    assign clipped = (raw_sum > SAT_MAX) ? SAT_MAX : raw_sum;

    // Next-state and next-credit selection
    always_comb begin
        state_d = state_q;
        total_d = total_q;
        unique case (state_q)
            ST_SHORT, ST_PAID: begin
                if (add_en) begin
                    total_d = clipped[TOTAL_W-1:0];
                    if (clipped == SAT_MAX) begin
                        state_d = ST_FULL;
                    end else if (clipped >= THR) begin
                        state_d = ST_PAID;
                    end else begin
                        state_d = ST_SHORT;
                    end
                end
            end
            ST_FULL: begin
                state_d = ST_FULL;
                total_d = total_q;
            end
            default: begin
                state_d = ST_SHORT;
                total_d = '0;
            end
        endcase
    end

    // State and credit register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SHORT;
            total_q <= '0;
        end else begin
            state_q <= state_d;
            total_q <= total_d;
        end
    end

    // Outputs decoded from registered state
    always_comb begin
        total = total_q;
        met   = 1'b0;
        unique case (state_q)
            ST_SHORT: met = 1'b0;
            ST_PAID:  met = 1'b1;
            ST_FULL:  met = 1'b1;
            default:  met = 1'b0;
        endcase
    end

endmodule

// File: rtl/coin_accumulator.sv
module coin_accumulator
    import coin_acc_pkg::*;
#(
    parameter int TOTAL_W     = 6,
    parameter int THRESHOLD   = 30,
    parameter int SYNC_STAGES = 2,
    parameter int NICKEL_VAL  = 5,
    parameter int DIME_VAL    = 10,
    parameter int QUARTER_VAL = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coin_pulse,
    input  logic               sel_nickel,
    input  logic               sel_dime,
    input  logic               sel_quarter,
    output logic [TOTAL_W-1:0] credit_total,
    output logic               credit_met
);

    logic [SEL_W-1:0]   sel_raw;
    logic [SEL_W-1:0]   sel_sync;
    logic               pulse_rise;
    logic               coin_ok;
    logic [TOTAL_W-1:0] coin_val;

    always_comb begin
        sel_raw                  = '0;
        sel_raw[SEL_NICKEL_BIT]  = sel_nickel;
        sel_raw[SEL_DIME_BIT]    = sel_dime;
        sel_raw[SEL_QUARTER_BIT] = sel_quarter;
    end

    coin_strobe_sync #(
        .STAGES (SYNC_STAGES),
        .DATA_W (SEL_W)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_in   (coin_pulse),
        .data_in     (sel_raw),
        .strobe_rise (pulse_rise),
        .data_out    (sel_sync)
    );

    coin_value_decode #(
        .VAL_W       (TOTAL_W),
        .NICKEL_VAL  (NICKEL_VAL),
        .DIME_VAL    (DIME_VAL),
        .QUARTER_VAL (QUARTER_VAL)
    ) u_decode (
        .sel      (sel_sync),
        .coin_ok  (coin_ok),
        .coin_val (coin_val)
    );

    credit_fsm #(
        .TOTAL_W   (TOTAL_W),
        .THRESHOLD (THRESHOLD)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (pulse_rise & coin_ok),
        .add_val (coin_val),
        .total   (credit_total),
        .met     (credit_met)
    );

endmodule

// File: rtl/coin_accumulator_checker.sv
module coin_accumulator_checker #(
    parameter int TOTAL_W     = 6,
    parameter int THRESHOLD   = 30,
    parameter int NICKEL_VAL  = 5,
    parameter int DIME_VAL    = 10,
    parameter int QUARTER_VAL = 25
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TOTAL_W-1:0] credit_total,
    input logic               credit_met
);

    localparam logic [TOTAL_W-1:0] TOP = TOTAL_W'((1 << TOTAL_W) - 1);

    // R1: first cycle out of reset shows a cleared credit
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (credit_total == '0) && !credit_met);

    // R8: flag agrees with the stored total at every edge
    assert_flag_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        credit_met == (credit_total >= TOTAL_W'(THRESHOLD)));

    // R9: no wrap, the credit never decreases
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> credit_total >= $past(credit_total));

    // R2 R3 R4: every change is one coin value or a clip to the top
    assert_step_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(credit_total) |->
            ((credit_total - $past(credit_total)) == TOTAL_W'(NICKEL_VAL)) ||
            ((credit_total - $past(credit_total)) == TOTAL_W'(DIME_VAL)) ||
            ((credit_total - $past(credit_total)) == TOTAL_W'(QUARTER_VAL)) ||
            (credit_total == TOP));

    // R6: a change is followed by at least one quiet cycle
    assert_single_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(credit_total) |=> $stable(credit_total));

endmodule

bind coin_accumulator coin_accumulator_checker #(
    .TOTAL_W     (TOTAL_W),
    .THRESHOLD   (THRESHOLD),
    .NICKEL_VAL  (NICKEL_VAL),
    .DIME_VAL    (DIME_VAL),
    .QUARTER_VAL (QUARTER_VAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .credit_total (credit_total),
    .credit_met   (credit_met)
);

// File: tb/tb_coin_accumulator.sv
`timescale 1ns/1ps
module tb_coin_accumulator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coin_pulse = 1'b0;
    logic       sel_nickel = 1'b0;
    logic       sel_dime = 1'b0;
    logic       sel_quarter = 1'b0;
    logic [5:0] credit_total;
    logic       credit_met;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coin_accumulator dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .coin_pulse   (coin_pulse),
        .sel_nickel   (sel_nickel),
        .sel_dime     (sel_dime),
        .sel_quarter  (sel_quarter),
        .credit_total (credit_total),
        .credit_met   (credit_met)
    );

    // {sel quarter,dime,nickel; hold cycles; expected total; expected flag; tag}
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {3'b001, 4'd1, 6'd5,  1'b0},   // R2
        {3'b010, 4'd1, 6'd15, 1'b0},   // R3
        {3'b011, 4'd1, 6'd15, 1'b0},   // R7 two lines
        {3'b000, 4'd1, 6'd15, 1'b0},   // R7 no line
        {3'b010, 4'd6, 6'd25, 1'b0},   // R6 held strobe, R8 below threshold
        {3'b001, 4'd1, 6'd30, 1'b1},   // R8 at threshold
        {3'b100, 4'd1, 6'd55, 1'b1},   // R4
        {3'b111, 4'd2, 6'd55, 1'b1},   // R7 all lines
        {3'b010, 4'd1, 6'd63, 1'b1},   // R9 clip
        {3'b100, 4'd1, 6'd63, 1'b1}    // R9 held at top
    };
    localparam string TAGS [NV] = '{"R2", "R3", "R7", "R7", "R6", "R8", "R4", "R7", "R9", "R9"};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic insert(input logic [2:0] sel, input int hold);
        @(negedge clk);
        {sel_quarter, sel_dime, sel_nickel} = sel;
        coin_pulse = 1'b1;
        cyc(hold);
        coin_pulse = 1'b0;
        cyc(4);
        {sel_quarter, sel_dime, sel_nickel} = 3'b000;
        cyc(1);
    endtask

    initial begin
        #40000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check("R1 total in reset", credit_total, 0);
        check("R1 flag in reset", credit_met, 0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 total after release", credit_total, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            insert(VEC[v][13:11], int'(VEC[v][10:7]));
            check({TAGS[v], " total"}, credit_total, int'(VEC[v][6:1]));
            check({TAGS[v], " flag"}, credit_met, int'(VEC[v][0]));
        end

        // R1: reset mid-stream clears everything
        rst_n = 1'b0;
        cyc(1);
        check("R1 total after reset", credit_total, 0);
        check("R1 flag after reset", credit_met, 0);
        rst_n = 1'b1;
        cyc(2);

        // R5: denomination lines move without a strobe
        for (int k = 0; k < 8; k++) begin
            {sel_quarter, sel_dime, sel_nickel} = 3'(k);
            cyc(2);
        end
        {sel_quarter, sel_dime, sel_nickel} = 3'b000;
        cyc(4);
        check("R5 no strobe total", credit_total, 0);

        // R10: latency of the strobe path
        @(negedge clk);
        sel_quarter = 1'b1;
        coin_pulse = 1'b1;
        cyc(2);
        check("R10 not yet after second edge", credit_total, 0);
        cyc(1);
        check("R10 visible after third edge", credit_total, 25);
        check("R8 flag with 25", credit_met, 0);
        coin_pulse = 1'b0;
        cyc(4);
        sel_quarter = 1'b0;

        // R8 flag rises on the same edge as the total, R2 from 25 to 30
        @(negedge clk);
        sel_nickel = 1'b1;
        coin_pulse = 1'b1;
        cyc(2);
        check("R8 flag before edge", credit_met, 0);
        cyc(1);
        check("R8 total at edge", credit_total, 30);
        check("R8 flag at edge", credit_met, 1);
        coin_pulse = 1'b0;
        cyc(4);
        sel_nickel = 1'b0;
        check("R5 stable afterwards", credit_total, 30);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule